// File: doc/BRIEF.md
# Weighted Transition Shift Power Meter

This block watches one scan chain of length `CHAIN_LEN` while it shifts. For every pattern it takes two bit streams: the stimulus entering the chain and the response leaving it. Each stream is scored by counting the bit-to-bit transitions and weighting each one by where it sits in the chain. A transition on the stimulus side is weighted by the distance it still has to travel. A transition on the response side is weighted by the distance it has already travelled.

The score for each finished pattern is held on the outputs. Over the run, the block also keeps a running total for each stream, the largest stimulus score seen, and a count of the patterns that were added to the totals. An average follows by dividing a total by the exported pattern count outside the block.

A pattern-start pulse arms the meter. Bits are taken only on cycles where the valid input is high. A synchronous clear input zeroes the run-level results.

Top module: `wtm_shift_power_meter`

## Requirements
- R1: After the asynchronous reset all outputs are zero, including `pat_done_o` and the pattern count.
- R2: Bits are numbered j = 1..CHAIN_LEN in order of arrival on cycles with `valid_i` high. The stimulus score of a pattern is the sum over j = 1..CHAIN_LEN-1 of (CHAIN_LEN - j) times (bit j XOR bit j+1) of `scan_in_i`. The first bit of a pattern contributes no transition.
- R3: The response score of a pattern is the sum over j = 1..CHAIN_LEN-1 of j times (bit j XOR bit j+1) of `scan_out_i`.
- R4: The CHAIN_LEN-th bit is taken at a rising edge. At that same edge both scores appear on `in_metric_o` and `out_metric_o`, and `pat_done_o` goes high for exactly one cycle. The scores then hold until the next pattern completes.
- R5: Each completed pattern adds its stimulus score to `in_total_o`, adds its response score to `out_total_o`, and increments `pat_count_o` by one.
- R6: `peak_in_o` is the largest stimulus score of any pattern completed since the last reset or clear.
- R7: A `start_i` pulse discards a partially shifted pattern. A bit taken together with `start_i` is bit 1 of the new pattern.
- R8: Bits presented before the first `start_i`, or after bit CHAIN_LEN and before the next `start_i`, are ignored. They produce no `pat_done_o` pulse and change no output.
- R9: `clear_i` zeroes `in_total_o`, `out_total_o`, `peak_in_o` and `pat_count_o` at the next edge but leaves the last per-pattern scores untouched. If a pattern completes in the same cycle, the clear wins for the run-level results, while the per-pattern scores still update.
- R10: Once `pat_count_o` equals MAX_PATTERNS, further patterns still update the per-pattern scores and the peak, but the totals and the count stay frozen, so the totals never overflow.
- R11: Idle cycles with `valid_i` low inside a pattern have no effect on its scores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of totals, peak and count |
| start_i | input | 1 | Pattern start pulse |
| valid_i | input | 1 | Bit qualifier for both streams |
| scan_in_i | input | 1 | Stimulus bit entering the chain |
| scan_out_i | input | 1 | Response bit leaving the chain |
| pat_done_o | output | 1 | One-cycle pulse when a pattern's scores are latched |
| in_metric_o | output | MET_W | Stimulus score of the last pattern |
| out_metric_o | output | MET_W | Response score of the last pattern |
| in_total_o | output | TOT_W | Accumulated stimulus scores |
| out_total_o | output | TOT_W | Accumulated response scores |
| peak_in_o | output | MET_W | Largest stimulus score |
| pat_count_o | output | CNT_W | Patterns added to the totals |

## Verification
The hardest condition to reach from the ports is a pattern that completes on the very cycle a clear is raised. Reaching it means counting valid bits exactly and placing `clear_i` on the cycle of the final bit. The bench's pattern task therefore takes a flag that raises `clear_i` together with the CHAIN_LEN-th bit. The count-limit freeze is reached by building the bench with a small MAX_PATTERNS and running one pattern past the limit.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
  // Largest per-pattern score: every adjacent pair toggles, weights 1..n-1.
  function automatic int max_metric(input int n);
    return n * (n - 1) / 2;
  endfunction

  function automatic int max_total(input int n, input int pats);
    return max_metric(n) * pats;
  endfunction
endpackage

// File: rtl/wtm_bit_tracker.sv
module wtm_bit_tracker #(
  parameter int CHAIN_LEN = 8,
  localparam int IDX_W = $clog2(CHAIN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             sin_i,
  input  logic             sout_i,
  output logic             accept_o,
  output logic             first_o,
  output logic             last_o,
  output logic             tin_o,
  output logic             tout_o,
  output logic [IDX_W-1:0] w_in_o,
  output logic [IDX_W-1:0] w_out_o
);
  logic             active_q;
  logic [IDX_W-1:0] cnt_q;
  logic             prev_in_q, prev_out_q;
  logic [IDX_W-1:0] pos;

  // pos = number of bits already taken in this pattern
  assign pos      = start_i ? '0 : cnt_q;
  assign accept_o = valid_i && (start_i || active_q);
  assign first_o  = (pos == '0);
  assign last_o   = accept_o && (pos == IDX_W'(CHAIN_LEN - 1));
  assign tin_o    = !first_o && (prev_in_q ^ sin_i);
  assign tout_o   = !first_o && (prev_out_q ^ sout_i);
  assign w_in_o   = IDX_W'(CHAIN_LEN) - pos;
  assign w_out_o  = pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      prev_in_q  <= 1'b0;
      prev_out_q <= 1'b0;
    end else if (accept_o) begin
      active_q   <= !last_o;
      cnt_q      <= pos + 1'b1;
      prev_in_q  <= sin_i;
      prev_out_q <= sout_i;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end
  end

  assert_idx_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= IDX_W'(CHAIN_LEN));
  assert_no_bit_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !active_q);
endmodule

// File: rtl/wtm_pattern_acc.sv
module wtm_pattern_acc #(
  parameter int CHAIN_LEN = 8,
  localparam int IDX_W = $clog2(CHAIN_LEN + 1),
  localparam int MET_W = $clog2(wtm_pkg::max_metric(CHAIN_LEN) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             accept_i,
  input  logic             first_i,
  input  logic             tin_i,
  input  logic             tout_i,
  input  logic [IDX_W-1:0] w_in_i,
  input  logic [IDX_W-1:0] w_out_i,
  output logic [MET_W-1:0] sum_in_o,
  output logic [MET_W-1:0] sum_out_o
);
  logic [MET_W-1:0] acc_in_q, acc_out_q;

  assign sum_in_o  = (first_i ? '0 : acc_in_q)  + (tin_i  ? MET_W'(w_in_i)  : '0);
  assign sum_out_o = (first_i ? '0 : acc_out_q) + (tout_i ? MET_W'(w_out_i) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_in_q  <= '0;
      acc_out_q <= '0;
    end else if (accept_i) begin
      acc_in_q  <= sum_in_o;
      acc_out_q <= sum_out_o;
    end else if (start_i) begin
      acc_in_q  <= '0;
      acc_out_q <= '0;
    end
  end

  assert_partial_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_in_q <= MET_W'(wtm_pkg::max_metric(CHAIN_LEN)));
  assert_partial_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_out_q <= MET_W'(wtm_pkg::max_metric(CHAIN_LEN)));
endmodule

// File: rtl/wtm_run_totals.sv
module wtm_run_totals #(
  parameter int CHAIN_LEN    = 8,
  parameter int MAX_PATTERNS = 1023,
  localparam int MET_W = $clog2(wtm_pkg::max_metric(CHAIN_LEN) + 1),
  localparam int TOT_W = $clog2(wtm_pkg::max_total(CHAIN_LEN, MAX_PATTERNS) + 1),
  localparam int CNT_W = $clog2(MAX_PATTERNS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             last_i,
  input  logic [MET_W-1:0] sum_in_i,
  input  logic [MET_W-1:0] sum_out_i,
  output logic             done_o,
  output logic [MET_W-1:0] in_metric_o,
  output logic [MET_W-1:0] out_metric_o,
  output logic [TOT_W-1:0] in_total_o,
  output logic [TOT_W-1:0] out_total_o,
  output logic [MET_W-1:0] peak_in_o,
  output logic [CNT_W-1:0] count_o
);
  logic room;
  assign room = (count_o != CNT_W'(MAX_PATTERNS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      in_metric_o  <= '0;
      out_metric_o <= '0;
    end else begin
      done_o <= last_i;
      if (last_i) begin
        in_metric_o  <= sum_in_i;
        out_metric_o <= sum_out_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_total_o  <= '0;
      out_total_o <= '0;
      peak_in_o   <= '0;
      count_o     <= '0;
    end else if (clear_i) begin
      in_total_o  <= '0;
      out_total_o <= '0;
      peak_in_o   <= '0;
      count_o     <= '0;
    end else if (last_i) begin
      if (sum_in_i > peak_in_o) peak_in_o <= sum_in_i;
      if (room) begin
        in_total_o  <= in_total_o  + TOT_W'(sum_in_i);
        out_total_o <= out_total_o + TOT_W'(sum_out_i);
        count_o     <= count_o + 1'b1;
      end
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (in_total_o >= $past(in_total_o)) && (out_total_o >= $past(out_total_o)));
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_peak_covers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(clear_i)) |-> peak_in_o >= in_metric_o);
  assert_count_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(MAX_PATTERNS));
  assert_clear_zeroes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0) && (peak_in_o == '0));
endmodule

// File: rtl/wtm_shift_power_meter.sv
module wtm_shift_power_meter #(
  parameter int CHAIN_LEN    = 8,
  parameter int MAX_PATTERNS = 1023,
  localparam int IDX_W = $clog2(CHAIN_LEN + 1),
  localparam int MET_W = $clog2(wtm_pkg::max_metric(CHAIN_LEN) + 1),
  localparam int TOT_W = $clog2(wtm_pkg::max_total(CHAIN_LEN, MAX_PATTERNS) + 1),
  localparam int CNT_W = $clog2(MAX_PATTERNS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             scan_in_i,
  input  logic             scan_out_i,
  output logic             pat_done_o,
  output logic [MET_W-1:0] in_metric_o,
  output logic [MET_W-1:0] out_metric_o,
  output logic [TOT_W-1:0] in_total_o,
  output logic [TOT_W-1:0] out_total_o,
  output logic [MET_W-1:0] peak_in_o,
  output logic [CNT_W-1:0] pat_count_o
);
  logic             accept, first, last, tin, tout;
  logic [IDX_W-1:0] w_in, w_out;
  logic [MET_W-1:0] sum_in, sum_out;

  wtm_bit_tracker #(.CHAIN_LEN(CHAIN_LEN)) u_track (
    .clk_i, .rst_ni, .start_i, .valid_i,
    .sin_i(scan_in_i), .sout_i(scan_out_i),
    .accept_o(accept), .first_o(first), .last_o(last),
    .tin_o(tin), .tout_o(tout), .w_in_o(w_in), .w_out_o(w_out)
  );

  wtm_pattern_acc #(.CHAIN_LEN(CHAIN_LEN)) u_acc (
    .clk_i, .rst_ni, .start_i, .accept_i(accept), .first_i(first),
    .tin_i(tin), .tout_i(tout), .w_in_i(w_in), .w_out_i(w_out),
    .sum_in_o(sum_in), .sum_out_o(sum_out)
  );

  wtm_run_totals #(.CHAIN_LEN(CHAIN_LEN), .MAX_PATTERNS(MAX_PATTERNS)) u_tot (
    .clk_i, .rst_ni, .clear_i, .last_i(last),
    .sum_in_i(sum_in), .sum_out_i(sum_out),
    .done_o(pat_done_o), .in_metric_o, .out_metric_o,
    .in_total_o, .out_total_o, .peak_in_o, .count_o(pat_count_o)
  );
endmodule

// File: tb/wtm_shift_power_meter_tb.sv
module wtm_shift_power_meter_tb;
  localparam int N = 8;
  localparam int MAXP = 5;
  localparam int MET_W = $clog2(N * (N - 1) / 2 + 1);
  localparam int TOT_W = $clog2(MAXP * N * (N - 1) / 2 + 1);
  localparam int CNT_W = $clog2(MAXP + 1);

  // {scan_in byte, scan_out byte, exp in score, exp out score}; bit 0 shifts first
  localparam logic [31:0] VEC [5] = '{
    {8'h00, 8'h00, 8'd0,  8'd0},
    {8'h55, 8'hFF, 8'd28, 8'd0},
    {8'h01, 8'h80, 8'd7,  8'd7},
    {8'h0F, 8'hF0, 8'd4,  8'd4},
    {8'h33, 8'hAA, 8'd12, 8'd28}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic clear_i = 1'b0, start_i = 1'b0, valid_i = 1'b0, sin = 1'b0, sout = 1'b0;
  logic             pat_done_o;
  logic [MET_W-1:0] in_metric_o, out_metric_o, peak_in_o;
  logic [TOT_W-1:0] in_total_o, out_total_o;
  logic [CNT_W-1:0] pat_count_o;

  int errors = 0, checks = 0, cycles = 0;
  int exp_in_tot = 0, exp_out_tot = 0, exp_peak = 0, exp_cnt = 0;

  always #4 clk = ~clk;

  wtm_shift_power_meter #(.CHAIN_LEN(N), .MAX_PATTERNS(MAXP)) u_dut (
    .clk_i(clk), .rst_ni, .clear_i, .start_i, .valid_i,
    .scan_in_i(sin), .scan_out_i(sout), .pat_done_o,
    .in_metric_o, .out_metric_o, .in_total_o, .out_total_o,
    .peak_in_o, .pat_count_o
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_run(input string req);
    chk({req, " in_total"}, int'(in_total_o), exp_in_tot);
    chk({req, " out_total"}, int'(out_total_o), exp_out_tot);
    chk({req, " peak"}, int'(peak_in_o), exp_peak);
    chk({req, " count"}, int'(pat_count_o), exp_cnt);
  endtask

  // Shift one pattern; gap inserts an idle cycle after every bit; clr raises clear_i with the last bit.
  task automatic send(input logic [7:0] vin, input logic [7:0] vout, input bit gap, input bit clr);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      start_i = (i == 0); valid_i = 1'b1; sin = vin[i]; sout = vout[i];
      clear_i = clr && (i == N - 1);
      if (gap && i < N - 1) begin
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0; sin = ~sin; sout = ~sout;
      end
    end
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic account(input int si, input int so);
    if (si > exp_peak) exp_peak = si;
    if (exp_cnt < MAXP) begin
      exp_in_tot += si; exp_out_tot += so; exp_cnt++;
    end
  endtask

  initial begin
    // R1 reset state
    #1;
    chk("R1 done", int'(pat_done_o), 0);
    chk("R1 in_metric", int'(in_metric_o), 0);
    chk("R1 out_metric", int'(out_metric_o), 0);
    chk_run("R1");
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R8 bits before any start are ignored
    for (int i = 0; i < 2 * N; i++) begin
      @(negedge clk);
      valid_i = 1'b1; sin = i[0]; sout = ~i[0];
      chk("R8 no done before start", int'(pat_done_o), 0);
    end
    @(negedge clk); valid_i = 1'b0;
    chk("R8 metric before start", int'(in_metric_o), 0);
    chk_run("R8 before start");

    // R2 R3 R4 R5 R6 table walk
    foreach (VEC[k]) begin
      send(VEC[k][31:24], VEC[k][23:16], 1'b0, 1'b0);
      account(int'(VEC[k][15:8]), int'(VEC[k][7:0]));
      chk("R4 done pulse", int'(pat_done_o), 1);
      chk("R2 in score", int'(in_metric_o), int'(VEC[k][15:8]));
      chk("R3 out score", int'(out_metric_o), int'(VEC[k][7:0]));
      chk_run("R5 R6");
      @(negedge clk);
      chk("R4 done one cycle", int'(pat_done_o), 0);
      chk("R4 in score held", int'(in_metric_o), int'(VEC[k][15:8]));
    end

    // R8 bits after the last one, before a new start
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      valid_i = 1'b1; sin = i[0]; sout = i[0];
      chk("R8 no done after last", int'(pat_done_o), 0);
    end
    @(negedge clk); valid_i = 1'b0;
    chk("R8 in score unchanged", int'(in_metric_o), 12);
    chk("R8 out score unchanged", int'(out_metric_o), 28);
    chk_run("R8 after last");

    // R10 count at limit: totals frozen, scores update
    send(8'h7F, 8'h00, 1'b0, 1'b0);
    account(1, 0);
    chk("R10 in score", int'(in_metric_o), 1);
    chk_run("R10 frozen");

    // R9 clear together with a completing pattern: clear wins
    send(8'h03, 8'h00, 1'b0, 1'b1);
    exp_in_tot = 0; exp_out_tot = 0; exp_peak = 0; exp_cnt = 0;
    chk("R9 score still latched", int'(in_metric_o), 6);
    chk_run("R9 clear wins");

    // R9 clear alone keeps the last scores
    send(8'h55, 8'h00, 1'b0, 1'b0);
    account(28, 0);
    chk_run("R6 after clear");
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    exp_in_tot = 0; exp_out_tot = 0; exp_peak = 0; exp_cnt = 0;
    chk("R9 score kept", int'(in_metric_o), 28);
    chk_run("R9 clear");

    // R7 restart abandons a partial pattern
    @(negedge clk); start_i = 1'b1; valid_i = 1'b1; sin = 1'b1; sout = 1'b1;
    @(negedge clk); start_i = 1'b0; sin = 1'b0; sout = 1'b0;
    @(negedge clk); sin = 1'b1; sout = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    chk("R7 no done on partial", int'(pat_done_o), 0);
    send(8'h01, 8'h80, 1'b0, 1'b0);
    account(7, 7);
    chk("R7 in score after restart", int'(in_metric_o), 7);
    chk("R7 out score after restart", int'(out_metric_o), 7);
    chk_run("R7");

    // R11 idle gaps inside a pattern
    send(8'h0F, 8'hAA, 1'b1, 1'b0);
    account(4, 28);
    chk("R11 in score with gaps", int'(in_metric_o), 4);
    chk("R11 out score with gaps", int'(out_metric_o), 28);
    chk_run("R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule